// File: doc/BRIEF.md
# Opcode-Selected Integer ALU

This block is a purely combinational arithmetic and logic unit for a datapath of configurable width, 32 bits by default. A 4-bit operation code picks one of six functions, applied to two operands: three bitwise logic operations (AND, OR, NOR), addition, subtraction and a signed set-if-less-than. The code map is sparse and fixed. Any code outside it gives an all-zero result.

The adder is one bit wider than the operands, so a carry bit comes out of addition and subtraction. Subtraction is built as A + ~B + 1. Its carry therefore reads 1 when no borrow occurs, which is when A >= B unsigned. A zero flag is raised whenever the result word is all zeros. The block has no clock. A surrounding pipeline stage registers the outputs.

Top module: `opcode_alu`

## Requirements
- R1: Code 0 (4'b0000) drives the result with the bitwise AND of the two operands.
- R2: Code 1 (4'b0001) drives the result with the bitwise OR of the two operands.
- R3: Code 12 (4'b1100) drives the result with the inverted bitwise OR (NOR) of the two operands.
- R4: Code 2 (4'b0010) drives the result with the low WIDTH bits of A+B, and the carry output with bit WIDTH of that sum.
- R5: Code 6 (4'b0110) drives the result with A-B modulo 2^WIDTH, and the carry output with 1 exactly when A >= B as unsigned numbers (no borrow).
- R6: Code 7 (4'b0111) gives result 1 when A is less than B as two's-complement signed numbers, and 0 otherwise. Bits above bit 0 are zero and carry is 0.
- R7: For the three logic codes (0, 1, 12) the carry output is 0.
- R8: Every other code (3, 4, 5, 8, 9, 10, 11, 13, 14, 15) gives a result of zero and carry 0.
- R9: The zero output is 1 exactly when every bit of the result is 0, whatever the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | WIDTH | First operand (minuend for subtraction) |
| opnd_b | input | WIDTH | Second operand (subtrahend for subtraction) |
| op_sel | input | 4 | Operation code |
| result | output | WIDTH | Operation result |
| zero | output | 1 | High when result is all zeros |
| carry | output | 1 | Adder carry-out; no-borrow for subtraction; 0 otherwise |

## Verification
The carry flag and the zero flag can both be set by the same operation, because both come from one adder pass. Two operand pairs provoke this: adding 0xFFFFFFFF and 1 wraps the result to zero with a carry out, and subtracting equal operands gives zero with "no borrow" carry set. In each case the result, carry and zero are compared at once against values worked out by hand. Set-if-less-than is also probed across the sign boundary, where an unsigned comparison would give the opposite answer.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_AND = 4'd0,
    OP_OR  = 4'd1,
    OP_ADD = 4'd2,
    OP_SUB = 4'd6,
    OP_SLT = 4'd7,
    OP_NOR = 4'd12
  } alu_op_e;

endpackage

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] and_o,
  output logic [WIDTH-1:0] or_o,
  output logic [WIDTH-1:0] nor_o
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign and_o[i] = a[i] & b[i];
    assign or_o[i]  = a[i] | b[i];
    assign nor_o[i] = ~(a[i] | b[i]);
  end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             subtract,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             lt_signed
);

  localparam int EXT_W = WIDTH + 1;
  localparam int MSB   = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [EXT_W-1:0] wide_sum;

  // The subtract path inverts B and injects the +1 as carry-in.
  assign b_eff    = subtract ? ~b : b;
  assign wide_sum = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, subtract};
  assign sum      = wide_sum[WIDTH-1:0];
  assign cout     = wide_sum[WIDTH];

  // Signed less-than: when the signs differ, A is less exactly when it is
  // negative; when they agree, the difference cannot overflow, so its sign
  // bit decides.
  always_comb begin
    if (a[MSB] != b[MSB]) lt_signed = a[MSB];
    else                  lt_signed = wide_sum[MSB];
  end

endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] value,
  output logic             is_zero
);

  assign is_zero = ~(|value);

endmodule

// File: rtl/opcode_alu.sv
module opcode_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [OP_W-1:0]  op_sel,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             carry
);

  logic [WIDTH-1:0] and_v, or_v, nor_v, sum_v;
  logic             cout_v, lt_v, sub_mode;

  assign sub_mode = (op_sel == OP_SUB) || (op_sel == OP_SLT);

  alu_logic_unit #(.WIDTH(WIDTH)) u_logic (
    .a     (opnd_a),
    .b     (opnd_b),
    .and_o (and_v),
    .or_o  (or_v),
    .nor_o (nor_v)
  );

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a         (opnd_a),
    .b         (opnd_b),
    .subtract  (sub_mode),
    .sum       (sum_v),
    .cout      (cout_v),
    .lt_signed (lt_v)
  );

  always_comb begin
    result = '0;
    carry  = 1'b0;
    case (op_sel)
      OP_AND: result = and_v;
      OP_OR:  result = or_v;
      OP_NOR: result = nor_v;
      OP_ADD: begin
        result = sum_v;
        carry  = cout_v;
      end
      OP_SUB: begin
        result = sum_v;
        carry  = cout_v;
      end
      OP_SLT: result = {{(WIDTH-1){1'b0}}, lt_v};
      default: begin
        result = '0;
        carry  = 1'b0;
      end
    endcase
  end

  alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
    .value   (result),
    .is_zero (zero)
  );

endmodule

// File: rtl/opcode_alu_chk.sv
module opcode_alu_chk
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] opnd_a,
  input logic [WIDTH-1:0] opnd_b,
  input logic [OP_W-1:0]  op_sel,
  input logic [WIDTH-1:0] result,
  input logic             zero,
  input logic             carry
);

  logic [WIDTH:0] ref_add;
  assign ref_add = {1'b0, opnd_a} + {1'b0, opnd_b};

  always_comb begin
    assert_add_carry_R4: assert (op_sel != OP_ADD || {carry, result} == ref_add)
      else $error("R4 add result/carry mismatch");
    assert_sub_noborrow_R5: assert (op_sel != OP_SUB || carry == (opnd_a >= opnd_b))
      else $error("R5 subtract carry mismatch");
    assert_slt_range_R6: assert (op_sel != OP_SLT || (result <= 1 && !carry))
      else $error("R6 set-less-than out of range");
    assert_logic_carry_R7: assert (!(op_sel == OP_AND || op_sel == OP_OR || op_sel == OP_NOR) || !carry)
      else $error("R7 carry set on logic op");
    assert_unused_zero_R8: assert ((op_sel == OP_AND || op_sel == OP_OR || op_sel == OP_NOR ||
                                    op_sel == OP_ADD || op_sel == OP_SUB || op_sel == OP_SLT) ||
                                   (result == '0 && !carry))
      else $error("R8 unused code produced output");
    assert_zero_flag_R9: assert (zero == (result == '0))
      else $error("R9 zero flag mismatch");
  end

endmodule

bind opcode_alu opcode_alu_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_opcode_alu.sv
`timescale 1ns / 1ps
module sim_opcode_alu;

  localparam int W      = 32;
  localparam int VW     = 4 + 3 * W + 2;
  localparam int NV     = 19;
  localparam time TCLK  = 20ns;

  logic clk = 1'b0;
  always #(TCLK / 2) clk = ~clk;

  logic [W-1:0] a, b, res;
  logic [3:0]   op;
  logic         z, c;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  opcode_alu #(.WIDTH(W)) u0 (
    .opnd_a (a), .opnd_b (b), .op_sel (op),
    .result (res), .zero (z), .carry (c)
  );

  // {op, a, b, expected result, expected carry, expected zero}
  localparam logic [VW-1:0] VEC [NV] = '{
    {4'd0,  32'hF0F0_00FF, 32'hFF00_0F0F, 32'hF000_000F, 1'b0, 1'b0}, // R1
    {4'd0,  32'hAAAA_AAAA, 32'h5555_5555, 32'h0000_0000, 1'b0, 1'b1}, // R1 R9
    {4'd1,  32'hF0F0_0000, 32'h0000_0F0F, 32'hF0F0_0F0F, 1'b0, 1'b0}, // R2
    {4'd1,  32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0}, // R2 R7
    {4'd12, 32'hF0F0_0000, 32'h0F0F_0000, 32'h0000_FFFF, 1'b0, 1'b0}, // R3
    {4'd12, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b1}, // R3 R9
    {4'd2,  32'h1234_5678, 32'h1111_1111, 32'h2345_6789, 1'b0, 1'b0}, // R4
    {4'd2,  32'h8000_0000, 32'h8000_0001, 32'h0000_0001, 1'b1, 1'b0}, // R4
    {4'd2,  32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 1'b1, 1'b1}, // R4 R9
    {4'd6,  32'h0000_000A, 32'h0000_0003, 32'h0000_0007, 1'b1, 1'b0}, // R5
    {4'd6,  32'h0000_0003, 32'h0000_000A, 32'hFFFF_FFF9, 1'b0, 1'b0}, // R5
    {4'd6,  32'h0000_0005, 32'h0000_0005, 32'h0000_0000, 1'b1, 1'b1}, // R5 R9
    {4'd7,  32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0001, 1'b0, 1'b0}, // R6
    {4'd7,  32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 1'b1}, // R6
    {4'd7,  32'h7FFF_FFFF, 32'h8000_0000, 32'h0000_0000, 1'b0, 1'b1}, // R6
    {4'd7,  32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 1'b0}, // R6
    {4'd7,  32'h0000_0005, 32'h0000_0005, 32'h0000_0000, 1'b0, 1'b1}, // R6
    {4'd3,  32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 1'b1}, // R8
    {4'd15, 32'h0000_0001, 32'h0000_0001, 32'h0000_0000, 1'b0, 1'b1}  // R8
  };

  function automatic string res_tag(input logic [3:0] code);
    case (code)
      4'd0:  return "R1";
      4'd1:  return "R2";
      4'd12: return "R3";
      4'd2:  return "R4";
      4'd6:  return "R5";
      4'd7:  return "R6";
      default: return "R8";
    endcase
  endfunction

  function automatic string carry_tag(input logic [3:0] code);
    if (code == 4'd0 || code == 4'd1 || code == 4'd12) return "R7";
    return res_tag(code);
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s op=%0d act=%h exp=%h", tag, op, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
    @(posedge clk);
    op = o; a = x; b = y;
    @(negedge clk);
  endtask

  initial begin
    op = 4'd0; a = '0; b = '0;
    @(negedge clk);
    // Idle state: AND of zeros, zero flag set
    check("R9", {31'd0, z}, 32'd1);
    check("R7", {31'd0, c}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      apply(v[VW-1 -: 4], v[VW-5 -: W], v[VW-5-W -: W]);
      check(res_tag(op),   res, v[W+1:2]);
      check(carry_tag(op), {31'd0, c}, {31'd0, v[1]});
      check("R9",          {31'd0, z}, {31'd0, v[0]});
    end

    // R8: sweep every unused code with nonzero operands
    for (int k = 0; k < 16; k++) begin
      if (k != 0 && k != 1 && k != 2 && k != 6 && k != 7 && k != 12) begin
        apply(k[3:0], 32'hDEAD_BEEF, 32'h0123_4567);
        check("R8", res, 32'd0);
        check("R8", {31'd0, c}, 32'd0);
      end
    end

    // R5: borrow across the sign boundary, 0 - 1
    apply(4'd6, 32'h0, 32'h1);
    check("R5", res, 32'hFFFF_FFFF);
    check("R5", {31'd0, c}, 32'd0);

    // R6 vs unsigned: most negative below zero
    apply(4'd7, 32'h8000_0000, 32'h0);
    check("R6", res, 32'd1);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(TCLK * 5000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule